// File: doc/BRIEF.md
# Vector Register Chaining Controller

This controller sits beside a file of vector registers and decides when vector instructions may start and when each pipe may move the next element. For every register it holds one in-flight producer and one in-flight consumer, each with its own element counter and active length. A newly issued instruction does not wait for the whole register to settle. A consumer may follow a producer that is still writing, one element behind it (chaining). A producer may overwrite a register that an earlier consumer is still draining, staying behind that consumer's position (tailgating).

Each register is served by two pipes. Pipe 0 moves even-numbered elements and pipe 1 moves odd-numbered elements, so a counter advances by zero, one or two elements per clock. The issue logic accepts an instruction (one destination, two sources, a length) only when the destination has no pending producer and neither source has a pending consumer. The pipes then follow the per-element ready outputs and report each moved element on a strobe.

Top module: `vrf_chain_ctl`

## Requirements
- R1: `iss_grant` is high exactly when `iss_valid` is high, the destination has no pending writer and neither source has a pending reader. A grant with nonzero length makes the writer and reader(s) pending, both starting at element 0.
- R2: A granted instruction with length zero leaves its registers free, so a following instruction to the same destination is granted.
- R3: A reader issued while its register has a pending writer (chaining) may take element e only when e is below that writer's count. It never runs ahead of the writer.
- R4: A writer issued while its register has a pending reader, or whose own instruction reads that register (tailgating), may write element e only when e is below that reader's count.
- R5: A reader with no earlier writer, or a writer with no earlier reader, is ready for every element below its length.
- R6: The ready and strobe bit 2*r+0 of register r belongs to the next even element and bit 2*r+1 to the next odd element. From count c the two offered elements are c and c+1.
- R7: A counter advances by the number of accepted strobes, 0, 1 or 2 per clock. A strobe on the pipe that does not own element c, given without the owning pipe's strobe, is ignored.
- R8: When a counter reaches its length, the register's writer or reader becomes free, the counter returns to 0 and any chaining or tailgating dependency on it is released.
- R9: No ready bit is raised for an element at or beyond the active length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src0 | input | $clog2(NREG) | First source register |
| iss_src1 | input | $clog2(NREG) | Second source register |
| iss_vl | input | $clog2(MAXVL+1) | Active vector length |
| iss_grant | output | 1 | Issue accepted this cycle |
| wr_stb | input | 2*NREG | Element written, bit 2*r+p for pipe p of register r |
| rd_stb | input | 2*NREG | Element read, same layout |
| wr_rdy | output | 2*NREG | Next element of pipe p of register r may be written |
| rd_rdy | output | 2*NREG | Next element of pipe p of register r may be read |

## Verification
On every cycle the assertions check that counters stay below their lengths while pending and sit at zero when free. They also check that a chained reader never passes its writer, that a tailgating writer never passes its reader, that counters step by at most two, and that claims and zero-length grants leave the expected state. Several behaviours are visible only in the bench's scenarios: grants refused for a busy destination or source, the exact per-pipe ready pattern as one side advances element by element, a lone strobe on the wrong pipe being ignored, and the release of a dependency when the other side completes.

// File: rtl/vrf_chain_ctl.sv
module vrf_chain_ctl #(
  parameter int NREG  = 8,
  parameter int MAXVL = 64,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(MAXVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_src0,
  input  logic [RW-1:0]   iss_src1,
  input  logic [CW-1:0]   iss_vl,
  output logic            iss_grant,
  input  logic [2*NREG-1:0] wr_stb,
  input  logic [2*NREG-1:0] rd_stb,
  output logic [2*NREG-1:0] wr_rdy,
  output logic [2*NREG-1:0] rd_rdy
);
  localparam logic [CW:0] ONE = 1;

  logic [NREG-1:0] wbusy, rbusy;

  assign iss_grant = iss_valid && !wbusy[iss_dst] && !rbusy[iss_src0] && !rbusy[iss_src1];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          wb_q, rb_q, wtail_q, rchain_q;
    logic [CW-1:0] wcnt_q, wvl_q, rcnt_q, rvl_q;
    logic          claim_w, claim_r;
    logic [CW:0]   wa, wbn, ra, rbn, wvx, rvx;
    logic          wok_a, wok_b, rok_a, rok_b;
    logic          w_own, w_oth, r_own, r_oth;
    logic          wfirst, wsecond, rfirst, rsecond;
    logic [CW-1:0] wnext, rnext;
    logic          wdone, rdone;

    assign claim_w = iss_grant && (iss_vl != '0) && (iss_dst == RW'(r));
    assign claim_r = iss_grant && (iss_vl != '0) &&
                     ((iss_src0 == RW'(r)) || (iss_src1 == RW'(r)));

    assign wa  = {1'b0, wcnt_q};
    assign wbn = wa + ONE;
    assign ra  = {1'b0, rcnt_q};
    assign rbn = ra + ONE;
    assign wvx = {1'b0, wvl_q};
    assign rvx = {1'b0, rvl_q};

    assign wok_a = wb_q && (wa  < wvx) && (!wtail_q  || wa  < ra);
    assign wok_b = wb_q && (wbn < wvx) && (!wtail_q  || wbn < ra);
    assign rok_a = rb_q && (ra  < rvx) && (!rchain_q || ra  < wa);
    assign rok_b = rb_q && (rbn < rvx) && (!rchain_q || rbn < wa);

    assign wr_rdy[2*r +: 2] = wcnt_q[0] ? {wok_a, wok_b} : {wok_b, wok_a};
    assign rd_rdy[2*r +: 2] = rcnt_q[0] ? {rok_a, rok_b} : {rok_b, rok_a};

    assign w_own = wr_stb[2*r + (wcnt_q[0] ? 1 : 0)];
    assign w_oth = wr_stb[2*r + (wcnt_q[0] ? 0 : 1)];
    assign r_own = rd_stb[2*r + (rcnt_q[0] ? 1 : 0)];
    assign r_oth = rd_stb[2*r + (rcnt_q[0] ? 0 : 1)];

    assign wfirst  = w_own && wok_a;
    assign wsecond = wfirst && w_oth && wok_b;
    assign rfirst  = r_own && rok_a;
    assign rsecond = rfirst && r_oth && rok_b;

    assign wnext = wcnt_q + CW'(wfirst) + CW'(wsecond);
    assign rnext = rcnt_q + CW'(rfirst) + CW'(rsecond);
    assign wdone = wb_q && (wnext == wvl_q);
    assign rdone = rb_q && (rnext == rvl_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wb_q <= 1'b0; wcnt_q <= '0; wvl_q <= '0; wtail_q <= 1'b0;
      end else if (claim_w) begin
        wb_q    <= 1'b1;
        wcnt_q  <= '0;
        wvl_q   <= iss_vl;
        wtail_q <= (rb_q && !rdone) || claim_r;
      end else begin
        if (wdone) begin
          wb_q <= 1'b0; wcnt_q <= '0;
        end else begin
          wcnt_q <= wnext;
        end
        if (rdone) wtail_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rb_q <= 1'b0; rcnt_q <= '0; rvl_q <= '0; rchain_q <= 1'b0;
      end else if (claim_r) begin
        rb_q     <= 1'b1;
        rcnt_q   <= '0;
        rvl_q    <= iss_vl;
        rchain_q <= wb_q && !wdone;
      end else begin
        if (rdone) begin
          rb_q <= 1'b0; rcnt_q <= '0;
        end else begin
          rcnt_q <= rnext;
        end
        if (wdone) rchain_q <= 1'b0;
      end
    end

    assign wbusy[r] = wb_q;
    assign rbusy[r] = rb_q;

    AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wb_q |-> (wcnt_q < wvl_q)); // R9
    AST_RCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rb_q |-> (rcnt_q < rvl_q)); // R9
    AST_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!wb_q |-> wcnt_q == '0) and (!rb_q |-> rcnt_q == '0)); // R8
    AST_CLAIM_START: assert property (@(posedge clk) disable iff (!rst_n)
      claim_w |=> (wb_q && wcnt_q == '0)); // R1
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_grant && iss_vl == '0 && iss_dst == RW'(r)) |=> !wb_q); // R2
    AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_q && rchain_q) |-> (rcnt_q <= wcnt_q)); // R3
    AST_TAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_q && wtail_q) |-> (wcnt_q <= rcnt_q)); // R4
    AST_WSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_q && $past(wb_q) && !$past(claim_w)) |->
        (wcnt_q >= $past(wcnt_q) && {1'b0, wcnt_q} <= {1'b0, $past(wcnt_q)} + 2)); // R7
  end
endmodule

// File: tb/sim_vrf_chain_ctl.sv
`timescale 1ns/1ps
module sim_vrf_chain_ctl;
  localparam int NREG = 8, MAXVL = 8, RW = 3, CW = 4;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0;
  logic [RW-1:0] iss_dst = 0, iss_src0 = 0, iss_src1 = 0;
  logic [CW-1:0] iss_vl = 0;
  logic iss_grant;
  logic [2*NREG-1:0] wr_stb = 0, rd_stb = 0, wr_rdy, rd_rdy;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vrf_chain_ctl #(.NREG(NREG), .MAXVL(MAXVL)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_src0(iss_src0), .iss_src1(iss_src1), .iss_vl(iss_vl), .iss_grant(iss_grant),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_rdy(wr_rdy), .rd_rdy(rd_rdy));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input int d, input int s0, input int s1, input int vl,
                       input int exp, input string tag);
    iss_valid = 1; iss_dst = RW'(d); iss_src0 = RW'(s0); iss_src1 = RW'(s1); iss_vl = CW'(vl);
    #1 chk(int'(iss_grant), exp, tag);
    tick;
    iss_valid = 0;
  endtask

  task automatic wstep(input int r, input logic [1:0] pat);
    wr_stb[2*r +: 2] = pat; tick; wr_stb = '0; #1;
  endtask

  task automatic rstep(input int r, input logic [1:0] pat);
    rd_stb[2*r +: 2] = pat; tick; rd_stb = '0; #1;
  endtask

  function automatic int wq(input int r); return int'(wr_rdy[2*r +: 2]); endfunction
  function automatic int rq(input int r); return int'(rd_rdy[2*r +: 2]); endfunction

  // expected ready pair for count c, length vl, limit lim (elements below lim allowed)
  function automatic int pair(input int c, input int vl, input int lim);
    int e0 = (c % 2 == 0) ? c : c + 1;
    int e1 = (c % 2 == 1) ? c : c + 1;
    return (((e1 < vl) && (e1 < lim)) ? 2 : 0) + (((e0 < vl) && (e0 < lim)) ? 1 : 0);
  endfunction

  task automatic drain;
    for (int i = 0; i < 60; i++) begin
      if (wr_rdy == '0 && rd_rdy == '0) break;
      wr_stb = wr_rdy; rd_stb = rd_rdy; tick;
      wr_stb = '0; rd_stb = '0; #1;
    end
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1; #1;
    chk(int'(wr_rdy), 0, "R1 reset wr_rdy");
    chk(int'(rd_rdy), 0, "R1 reset rd_rdy");
    issue(0, 0, 0, 0, 1, "R2 zero length grant");
    issue(0, 0, 0, 0, 1, "R2 zero length regrant");
    chk(int'(wr_rdy), 0, "R2 nothing pending");

    // chaining
    issue(1, 2, 3, 7, 1, "R1 first writer");
    chk(rq(2), 3, "R5 free reader ready");
    chk(wq(1), 3, "R5 free writer ready");
    issue(4, 1, 1, 7, 1, "R1 chained reader grant");
    chk(rq(1), 0, "R3 nothing written yet");
    issue(1, 5, 5, 3, 0, "R1 second writer stalls");
    issue(6, 1, 0, 3, 0, "R1 busy source stalls");
    wstep(1, 2'b10);
    chk(rq(1), 0, "R7 lone odd strobe ignored");
    for (int w = 0; w < 7; w++) begin
      chk(rq(1), pair(0, 7, w), $sformatf("R3 chain w=%0d", w));
      wstep(1, (w % 2 == 0) ? 2'b01 : 2'b10);
    end
    chk(wq(1), 0, "R8 writer freed");
    chk(rq(1), 3, "R8 chain released");
    rstep(1, 2'b11);
    chk(rq(1), pair(2, 7, 99), "R6 reader at 2");

    // tailgating: reg1 reader at 2, no writer
    issue(1, 5, 6, 7, 1, "R1 tailgating writer grant");
    chk(wq(1), 3, "R4 behind reader");
    wstep(1, 2'b11);
    chk(wq(1), 0, "R4 caught up with reader");
    for (int r = 2; r < 7; r++) begin
      rstep(1, (r % 2 == 0) ? 2'b01 : 2'b10);
      if (r + 1 < 7) chk(wq(1), pair(2, 7, r + 1), $sformatf("R4 tail r=%0d", r + 1));
    end
    chk(wq(1), pair(2, 7, 99), "R8 tail released");
    wstep(1, 2'b11); wstep(1, 2'b11);
    chk(wq(1), 1, "R9 last element only");
    wstep(1, 2'b11);
    chk(wq(1), 0, "R8 writer done");
    drain;
    chk(int'(wr_rdy | rd_rdy), 0, "R8 all drained");

    // pipe mapping and counter reset
    issue(3, 7, 7, 5, 1, "R1 fresh writer");
    chk(wq(3), 3, "R8 counter from zero");
    wstep(3, 2'b01);
    chk(wq(3), pair(1, 5, 99), "R6 odd count");
    drain;
    issue(2, 0, 0, 1, 1, "R1 length one");
    chk(wq(2), 1, "R9 length one writer");
    chk(rq(0), 1, "R9 length one reader");
    wstep(2, 2'b11);
    chk(wq(2), 0, "R7 only one accepted");
    issue(2, 4, 4, 2, 1, "R8 destination reusable");
    drain;

    // dual pipe chaining
    issue(5, 0, 0, 4, 1, "R1 writer reg5");
    issue(6, 5, 5, 4, 1, "R1 chained reader reg5");
    wstep(5, 2'b11);
    chk(rq(5), 3, "R3 two written");
    rstep(5, 2'b11);
    chk(rq(5), 0, "R3 reader waits");
    wstep(5, 2'b11);
    chk(rq(5), 3, "R8 chain done");
    issue(6, 5, 5, 4, 0, "R1 reader still pending");
    drain;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule